// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog timer that software controls through a small register port. Once enabled, a counter advances every clock. Software must keep restarting it by writing a clear register. If it fails to do so in time, the block drives a reset request for a fixed number of cycles. In basic mode a clear is accepted at any moment before the timeout. In window mode the count is split into two halves of equal length. The first half is a ban interval, in which a clear is treated as a fault of runaway code. The second half is the open interval, in which the clear is expected.

After a reset request ends, the watchdog either keeps running from a zero count or switches itself off, depending on a disable-after-trip bit. An auto-enable fuse input sets the power-up state of the enable bit. Unless a fuse-override bit is set, the fuse also prevents software from choosing the switch-off behaviour. Control writes take effect only when they carry a key byte, so a stray write cannot reconfigure the timer.

Top module: `windowed_wdt`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the control readback (address 0) has EN equal to `fuse_auto_en` and every other field at 0. `wdt_rst` is low and the count readback (address 2) is 0.
- R2: A write to address 0 is applied only when bits 31:24 equal 8'hC3. Field positions are EN bit 0, WIN bit 1, DAR bit 2, FCD bit 3 and PSEL bits 12:8, and readback uses the same positions with all other bits 0. A write with any other key leaves the control register unchanged.
- R3: The period is T = 2^(PSEL+1) cycles. While enabled and not tripping, the count readback rises by one per cycle, starting from 0 in the cycle after EN is set. In basic mode (WIN=0), with no clear, `wdt_rst` rises T cycles after the write edge that enabled the timer.
- R4: `wdt_rst` stays high for exactly 4 consecutive cycles per trip, and the count reads 0 throughout.
- R5: A clear is a write to address 1 with bit 0 set. In basic mode it returns the count to 0 at any count value. This includes the last cycle of the period, and a clear there suppresses the trip.
- R6: In window mode, a clear while the count is below T (the ban interval) makes `wdt_rst` rise in the next cycle.
- R7: In window mode, a clear while the count is between T and 2T-1 returns the count to 0, which starts a new ban interval. With no clear, `wdt_rst` rises 2T cycles after the count left 0.
- R8: A write to WIN is ignored while EN is 1.
- R9: With DAR=0, EN stays 1 after a trip, and the count restarts from 0 in the first cycle after `wdt_rst` falls.
- R10: With DAR=1, EN reads 0 once `wdt_rst` has fallen, and all other control fields are unchanged.
- R11: While `fuse_auto_en` is 1 and the stored FCD is 0, a control write stores DAR as 0 whatever its bit 2 holds. With FCD=1 stored, DAR takes the written value.
- R12: While EN is 0, the count stays 0, clear writes have no effect, and `wdt_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| fuse_auto_en | input | 1 | Auto-enable fuse level; sets EN at reset and can lock DAR |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 clear |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 control, 2 count |
| rd_data | output | 32 | Combinational read data |
| wdt_rst | output | 1 | Watchdog reset request, 4 cycles per trip |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both. In the first, a clear write lands in the very cycle in which the timeout would expire. The clear must win: the count is expected to read 0 and `wdt_rst` to stay low. In the second, in window mode, clear writes are aimed at count T-1 and at count T, the last ban cycle and the first open cycle. The first of these must trip on the next cycle and the second must not. The bench steers each write by watching the count readback. A behavioural model, updated at every edge, judges the reset output and the count in every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PSEL_W = 5;
    localparam int CNT_W  = (1 << PSEL_W) + 2;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [7:0] CTRL_KEY = 8'hC3;
    localparam int KEY_LSB  = 24;
    localparam int EN_BIT   = 0;
    localparam int WIN_BIT  = 1;
    localparam int DAR_BIT  = 2;
    localparam int FCD_BIT  = 3;
    localparam int PSEL_LSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_CLEAR = 2'd1,
        REG_COUNT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic              fcd;
        logic              dar;
        logic              win;
        logic              en;
    } wdt_ctrl_t;

    // Length of one interval (ban or timeout) for a prescaler select.
    function automatic logic [CNT_W-1:0] period_of(input logic [PSEL_W-1:0] sel);
        return {{(CNT_W-1){1'b0}}, 1'b1} << ({1'b0, sel} + (PSEL_W+1)'(1));
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_readback(input wdt_ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[EN_BIT]  = c.en;
        v[WIN_BIT] = c.win;
        v[DAR_BIT] = c.dar;
        v[FCD_BIT] = c.fcd;
        v[PSEL_LSB +: PSEL_W] = c.psel;
        return v;
    endfunction

endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fuse_auto_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              release_i,
    output wdt_ctrl_t         ctrl_o,
    output logic              clr_req_o
);

    wdt_ctrl_t         ctrl_q;
    wdt_ctrl_t         ctrl_d;
    logic              key_ok;
    logic              ctrl_wr;
    logic              dar_locked;
    logic [DATA_W-1:0] data_unused;

    assign data_unused = wr_data;
    assign key_ok      = (wr_data[KEY_LSB +: 8] == CTRL_KEY);
    assign ctrl_wr     = wr_en && (wr_addr == REG_CTRL) && key_ok;
    assign dar_locked  = fuse_auto_en && !ctrl_q.fcd;
    assign clr_req_o   = wr_en && (wr_addr == REG_CLEAR) && wr_data[0];

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.en   = wr_data[EN_BIT];
            ctrl_d.fcd  = wr_data[FCD_BIT];
            ctrl_d.dar  = wr_data[DAR_BIT] && !dar_locked;
            ctrl_d.psel = wr_data[PSEL_LSB +: PSEL_W];
            if (!ctrl_q.en) begin
                ctrl_d.win = wr_data[WIN_BIT];
            end
        end
        // End of a trip with disable-after-trip set: only EN changes.
        if (release_i && ctrl_q.dar) begin
            ctrl_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{psel: '0, fcd: 1'b0, dar: 1'b0, win: 1'b0, en: fuse_auto_en};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/wdt_window_counter.sv
module wdt_window_counter
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              win,
    input  logic [PSEL_W-1:0] psel,
    input  logic              clr_req,
    input  logic              hold,
    output logic              fire_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] limit;
    logic             active;
    logic             in_ban;
    logic             violation;
    logic             clr_ok;
    logic             expire;

    assign period    = period_of(psel);
    assign limit     = win ? ((period << 1) - 1'b1) : (period - 1'b1);
    assign active    = en && !hold;
    assign in_ban    = win && (cnt_q < period);
    assign violation = active && clr_req && in_ban;
    assign clr_ok    = active && clr_req && !in_ban;
    // A clear in the last open cycle wins over the expiry.
    assign expire    = active && !clr_req && (cnt_q >= limit);
    assign fire_o    = violation || expire;

    always_ff @(posedge clk) begin
        if (rst || !active || clr_ok || fire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse_o,
    output logic release_o
);

    localparam int LW = $clog2(PULSE_LEN + 1);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= LW'(PULSE_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pulse_o   = (left_q != '0);
    assign release_o = (left_q == LW'(1));

endmodule

// File: rtl/windowed_wdt.sv
module windowed_wdt
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fuse_auto_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        wdt_rst
);

    wdt_ctrl_t        ctrl_q;
    logic             clr_req;
    logic             fire;
    logic             pulse;
    logic             pulse_release;
    logic [CNT_W-1:0] cnt;

    wdt_ctrl_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .fuse_auto_en (fuse_auto_en),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .release_i    (pulse_release),
        .ctrl_o       (ctrl_q),
        .clr_req_o    (clr_req)
    );

    wdt_window_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.en),
        .win     (ctrl_q.win),
        .psel    (ctrl_q.psel),
        .clr_req (clr_req),
        .hold    (pulse),
        .fire_o  (fire),
        .cnt_o   (cnt)
    );

    wdt_reset_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .pulse_o   (pulse),
        .release_o (pulse_release)
    );

    always_comb begin
        case (rd_addr)
            REG_CTRL:  rd_data = ctrl_readback(ctrl_q);
            REG_COUNT: rd_data = DATA_W'(cnt);
            default:   rd_data = '0;
        endcase
    end

    assign wdt_rst = pulse;

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wdt_rst,
    input logic              en,
    input logic              win,
    input logic              dar,
    input logic              fcd,
    input logic              fuse,
    input logic [PSEL_W-1:0] psel,
    input logic [CNT_W-1:0]  cnt,
    input logic              clr_req
);

    logic [CNT_W-1:0] period;
    int unsigned      run_len;

    assign period = period_of(psel);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= 0;
        end else if (wdt_rst) begin
            run_len <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    // R4: pulse length is exact
    a_r4_pulse_length: assert property (@(posedge clk) disable iff (rst)
        $fell(wdt_rst) |-> (run_len == PULSE_LEN));
    a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> (run_len < PULSE_LEN));
    // R4: count parked while the request is high
    a_r4_count_parked: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> (cnt == '0));
    // R3: basic-mode expiry trips
    a_r3_basic_expiry: assert property (@(posedge clk) disable iff (rst)
        (en && !wdt_rst && !win && !clr_req && (cnt >= period - 1'b1)) |=> wdt_rst);
    // R6: clear in the ban interval trips
    a_r6_ban_clear: assert property (@(posedge clk) disable iff (rst)
        (en && !wdt_rst && win && clr_req && (cnt < period)) |=> wdt_rst);
    // R8: mode frozen while enabled
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(win));
    // R10: disable after trip
    a_r10_dar_off: assert property (@(posedge clk) disable iff (rst)
        ($fell(wdt_rst) && $past(dar)) |-> !en);
    // R11: fuse lock on DAR
    a_r11_dar_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(dar) |-> $past(!fuse || fcd));

endmodule

bind windowed_wdt wdt_checker #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wdt_rst (wdt_rst),
    .en      (ctrl_q.en),
    .win     (ctrl_q.win),
    .dar     (ctrl_q.dar),
    .fcd     (ctrl_q.fcd),
    .fuse    (fuse_auto_en),
    .psel    (ctrl_q.psel),
    .cnt     (cnt),
    .clr_req (clr_req)
);

// File: tb/sim_windowed_wdt.sv
module sim_windowed_wdt;

    localparam int CLK_P = 10;
    localparam int PULSE = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        fuse_auto_en;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        wdt_rst;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    windowed_wdt #(.PULSE_LEN(PULSE)) u0 (
        .clk          (clk),
        .rst          (rst),
        .fuse_auto_en (fuse_auto_en),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .wdt_rst      (wdt_rst)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit     m_en, m_win, m_dar, m_fcd;
    int     m_psel;
    longint m_cnt;
    int     m_left;
    longint t_len, t_lim;
    bit     t_hold, t_act, t_clr, t_ban, t_fire, t_en;

    always @(posedge clk) begin
        if (rst) begin
            m_en <= fuse_auto_en; m_win <= 0; m_dar <= 0; m_fcd <= 0;
            m_psel <= 0; m_cnt <= 0; m_left <= 0;
        end else begin
            t_len  = longint'(1) << (m_psel + 1);
            t_lim  = m_win ? (2 * t_len - 1) : (t_len - 1);
            t_hold = (m_left != 0);
            t_act  = m_en && !t_hold;
            t_clr  = wr_en && (wr_addr == 2'd1) && wr_data[0];
            t_ban  = m_win && (m_cnt < t_len);
            t_fire = t_act && ((t_clr && t_ban) || (!t_clr && m_cnt >= t_lim));
            if (!t_act || t_fire || t_clr) m_cnt <= 0;
            else m_cnt <= m_cnt + 1;
            m_left <= t_fire ? PULSE : (t_hold ? m_left - 1 : 0);
            t_en = m_en;
            if (wr_en && wr_addr == 2'd0 && wr_data[31:24] == 8'hC3) begin
                t_en = wr_data[0];
                if (!m_en) m_win <= wr_data[1];
                m_fcd  <= wr_data[3];
                m_dar  <= wr_data[2] && !(fuse_auto_en && !m_fcd);
                m_psel <= int'(wr_data[12:8]);
            end
            if (m_left == 1 && m_dar) t_en = 0;
            m_en <= t_en;
        end
    end

    // every-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (!done) begin
            chk(wdt_rst === (m_left != 0), "R4", longint'(wdt_rst), longint'(m_left != 0));
            if (rd_addr == 2'd2)
                chk(rd_data === m_cnt[31:0], "R3", longint'(rd_data), longint'(m_cnt[31:0]));
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    function automatic logic [31:0] cw(input bit en, input bit win, input bit dar,
                                       input bit fcd, input logic [4:0] psel);
        return {8'hC3, 11'b0, psel, 4'b0, fcd, dar, win, en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic read_ctrl(output logic [31:0] v);
        rd_addr = 2'd0;
        #1;
        v = rd_data;
        rd_addr = 2'd2;
        #1;
    endtask

    task automatic wait_count(input logic [31:0] v);
        while (rd_data != v) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_trip_end();
        while (!wdt_rst) @(negedge clk);
        while (wdt_rst) @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired, run hung");
        summary();
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; fuse_auto_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 2'd2;
        idle(3);
        rst = 1'b0;

        // R1: reset state with fuse low
        read_ctrl(v);
        chk(v == 32'h0, "R1 ctrl", v, 0);
        chk(wdt_rst == 1'b0, "R1 wdt_rst", wdt_rst, 0);
        chk(rd_data == 0, "R1 count", rd_data, 0);

        // R2: wrong key leaves control untouched
        wr(2'd0, {8'h3C, cw(1, 1, 0, 0, 5'd2)} [31:0] & 32'h00FF_FFFF | 32'h3C00_0000);
        read_ctrl(v);
        chk(v == 32'h0, "R2 bad key", v, 0);

        // R3: basic mode, T = 8, trip 8 cycles after the enabling edge
        wr(2'd0, cw(1, 0, 0, 0, 5'd2));
        read_ctrl(v);
        chk(v == 32'h0000_0201, "R2 readback", v, 32'h201);
        idle(7);
        chk(wdt_rst == 1'b0, "R3 before timeout", wdt_rst, 0);
        idle(1);
        chk(wdt_rst == 1'b1, "R3 timeout", wdt_rst, 1);
        idle(3);
        chk(wdt_rst == 1'b1 && rd_data == 0, "R4 held", wdt_rst, 1);
        idle(1);
        chk(wdt_rst == 1'b0, "R4 released", wdt_rst, 0);
        read_ctrl(v);
        chk(v[0] == 1'b1, "R9 still enabled", v[0], 1);
        chk(rd_data == 0, "R9 count zero", rd_data, 0);
        idle(1);
        chk(rd_data == 1, "R9 restarted", rd_data, 1);

        // R5: regular clears keep it alive, then a clear on the expiry cycle
        for (int i = 0; i < 6; i++) begin
            wait_count(32'd5);
            wr(2'd1, 32'h1);
        end
        wait_count(32'd7);
        wr(2'd1, 32'h1);
        chk(wdt_rst == 1'b0, "R5 clear beats expiry", wdt_rst, 0);
        chk(rd_data == 0, "R5 count cleared", rd_data, 0);

        // R8: mode write ignored while enabled
        wr(2'd0, cw(1, 1, 0, 0, 5'd2));
        read_ctrl(v);
        chk(v[1] == 1'b0, "R8 WIN locked", v[1], 0);

        // R12: disabled timer ignores clears and stays idle
        wr(2'd0, cw(0, 0, 0, 0, 5'd2));
        idle(20);
        chk(rd_data == 0 && wdt_rst == 0, "R12 idle", rd_data, 0);
        wr(2'd1, 32'h1);
        chk(rd_data == 0 && wdt_rst == 0, "R12 clear ignored", wdt_rst, 0);

        // R6/R7: window mode, T = 8
        wr(2'd0, cw(0, 1, 0, 0, 5'd2));
        wr(2'd0, cw(1, 1, 0, 0, 5'd2));
        wait_count(32'd3);
        wr(2'd1, 32'h1);
        chk(wdt_rst == 1'b1, "R6 ban clear trips", wdt_rst, 1);
        while (wdt_rst) @(negedge clk);
        wait_count(32'd7);
        wr(2'd1, 32'h1);
        chk(wdt_rst == 1'b1, "R6 last ban cycle", wdt_rst, 1);
        while (wdt_rst) @(negedge clk);
        wait_count(32'd8);
        wr(2'd1, 32'h1);
        chk(wdt_rst == 1'b0 && rd_data == 0, "R7 first open cycle", wdt_rst, 0);
        idle(15);
        chk(wdt_rst == 1'b0, "R7 before window end", wdt_rst, 0);
        idle(1);
        chk(wdt_rst == 1'b1, "R7 window timeout", wdt_rst, 1);
        while (wdt_rst) @(negedge clk);

        // R10: disable after trip
        wr(2'd0, cw(1, 1, 1, 0, 5'd1));
        wait_trip_end();
        read_ctrl(v);
        chk(v == 32'h0000_0106, "R10 only EN cleared", v, 32'h106);

        // R11: fuse locks DAR unless FCD set
        fuse_auto_en = 1'b1;
        wr(2'd0, cw(0, 0, 1, 0, 5'd1));
        read_ctrl(v);
        chk(v == 32'h0000_0100, "R11 DAR locked", v, 32'h100);
        wr(2'd0, cw(0, 0, 0, 1, 5'd1));
        wr(2'd0, cw(0, 0, 1, 1, 5'd1));
        read_ctrl(v);
        chk(v == 32'h0000_010C, "R11 DAR with FCD", v, 32'h10C);

        // R1: reset with the fuse set enables the timer
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        read_ctrl(v);
        chk(v == 32'h1, "R1 fuse enable", v, 1);
        chk(rd_data == 0, "R1 count after reset", rd_data, 0);
        idle(40);
        summary();
    end

endmodule